// File: doc/BRIEF.md
# Oscillator Watchdog Clock Supervisor

This block decides which clock drives a processor core and whether that core is held in reset. It compares an external oscillator against a free-running internal RC clock. The comparison counts rising edges of the external clock inside windows of a fixed number of RC cycles. The external clock is trusted only when it is strictly faster than the RC clock. If it is not, the core is held in reset and fed from the RC clock. The block then reports the condition on a status output that software can only read.

A recovered oscillator does not reach the core at once. It must first win several comparison windows in a row. A fixed stabilisation delay, timed in RC cycles, follows. If any window fails during that delay, qualification starts again. The same qualification follows the release of the hardware power-down pin, and the wake from software power-down. In the wake case the core keeps its state: its clock stays gated and reset is never asserted.

The switch between the two sources uses a two-flop handshake in each clock domain, so no shortened pulse can reach the core. If the external clock stops dead, the handshake cannot complete. A timer in the RC domain then forces the external side off.

Top module: `osw_supervisor`

## Requirements
- R1: While `rst_n` is low, `core_rst_n` is 0 and `osc_fail_sts` is 1. After reset the core runs from the RC clock until the external clock has been qualified.
- R2: A comparison window is good only when the number of external rising edges in WIN_CYC RC cycles is greater than WIN_CYC. An external clock at the same frequency as the RC clock never qualifies, and neither does a stopped one.
- R3: `core_rst_n` rises only after GOOD_WIN consecutive good windows, followed by DELAY_CYC RC cycles. Measured from the cycle where a fast external clock appears, the release happens no earlier than GOOD_WIN*WIN_CYC+DELAY_CYC cycles and no later than (GOOD_WIN+1)*WIN_CYC+DELAY_CYC+8 cycles. `core_clk` then follows the external clock.
- R4: While the watchdog holds the core (qualification or delay after a failure, reset or hardware power-down), `core_clk` follows the RC clock, `core_rst_n` is 0 and `osc_fail_sts` is 1.
- R5: In normal running, a slow or stopped external clock drives `core_rst_n` low and `osc_fail_sts` high within 2*WIN_CYC+4 RC cycles. The core then falls back to the RC clock.
- R6: A failing window during the stabilisation delay abandons the delay. A full new qualification (R3) is then required.
- R7: While `hwpd_n` is low, `core_rst_n` is 0, `core_clk` is stopped and `osc_fail_sts` is 0. After `hwpd_n` rises, the core is held on the RC clock with `osc_fail_sts` at 1 until a full qualification (R3) completes.
- R8: While `run_req` is low (software power-down), `core_clk` is stopped and `core_rst_n` stays 1. After `run_req` rises, `core_clk` stays stopped and `core_rst_n` stays 1 until a full qualification (R3). Then `core_clk` follows the external clock.
- R9: The RC source and the external source are never enabled together. No `core_clk` pulse is shorter than the shorter half-period of the two sources.
- R10: `osc_fail_sts` is 1 only while `core_rst_n` is 0. It has no write path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rc_clk | input | 1 | Internal RC reference clock; clocks all supervisor logic |
| rst_n | input | 1 | Synchronous active-low reset (RC domain) |
| ext_clk | input | 1 | External oscillator clock under supervision |
| hwpd_n | input | 1 | Hardware power-down pin, active low, asynchronous |
| run_req | input | 1 | Wake-up request level; low selects software power-down |
| core_clk | output | 1 | Clock delivered to the core (RC, external or stopped) |
| core_rst_n | output | 1 | Active-low reset hold for the core |
| osc_fail_sts | output | 1 | Read-only watchdog status: core held because of the oscillator |

## Verification
The external clock is driven at about 2.5 times the RC rate, at half the RC rate, at exactly the RC rate and stopped. These patterns separate a strict "faster than" comparison from one that would accept equal frequency or a dead oscillator. Recovery is checked both for a clean fast clock and for a clock that starts slow after power-down. A time point before the earliest legal release and one after the latest legal release bound the qualification and delay path. A slow spell inside the delay shows whether the delay is abandoned or wrongly resumed. The core clock is classified by counting its edges over 20 RC cycles (stopped, RC rate or external rate), and its narrowest pulse is tracked to catch runt pulses at each source change.

// File: rtl/osw_pkg.sv
`timescale 1ns/1ps
// Package: shared state type for the oscillator watchdog supervisor.
// Assumes: consumers import the package; no other shared items needed.
package osw_pkg;

    typedef enum logic [2:0] {
        ST_QUAL  = 3'd0,   // waiting for consecutive good windows
        ST_DELAY = 3'd1,   // stabilisation delay timed by RC cycles
        ST_RUN   = 3'd2,   // external clock feeds core
        ST_PD    = 3'd3,   // hardware power-down
        ST_SLEEP = 3'd4    // software power-down, clock gated
    } osw_state_e;

endpackage

// File: rtl/osw_sync.sv
`timescale 1ns/1ps
// Module: two-flop synchronizer for a single asynchronous level.
// Assumes: input changes slowly relative to clk; RST_VAL is the safe level.
module osw_sync #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic stage1;

    // Two-stage capture of the asynchronous input into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q_sync <= RST_VAL;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end
endmodule

// File: rtl/osw_edge_meter.sv
`timescale 1ns/1ps
// Module: counts external rising edges per window of WIN_CYC RC cycles.
// A Gray-coded counter crosses from the external domain into the RC domain.
// Assumes: external/RC ratio below 2**CNT_W / WIN_CYC; the first window
// after reset is discarded because the counter base is unknown.
module osw_edge_meter #(
    parameter int WIN_CYC = 16,
    parameter int CNT_W   = 8
) (
    input  logic rc_clk,
    input  logic rst_n,
    input  logic ext_clk,
    output logic win_done,
    output logic win_fast
);
    localparam int WC_W = $clog2(WIN_CYC);
    localparam logic [WC_W-1:0]  WC_LAST = WC_W'(WIN_CYC - 1);
    localparam logic [CNT_W-1:0] WIN_REF = CNT_W'(WIN_CYC);

    logic [CNT_W-1:0] e_bin, e_nxt, e_gray;
    logic [CNT_W-1:0] g_s1, g_s2, b_now, b_prev, span;
    logic [WC_W-1:0]  wcnt;
    logic             primed;

    assign e_nxt = e_bin + 1'b1;

    // External domain: free-running binary and registered Gray count.
    always_ff @(posedge ext_clk) begin
        e_bin  <= e_nxt;
        e_gray <= e_nxt ^ (e_nxt >> 1);
    end

    // RC domain: two-flop capture of the Gray count.
    always_ff @(posedge rc_clk) begin
        if (!rst_n) begin
            g_s1 <= '0;
            g_s2 <= '0;
        end else begin
            g_s1 <= e_gray;
            g_s2 <= g_s1;
        end
    end

    // Gray to binary conversion of the captured count.
    always_comb begin
        b_now[CNT_W-1] = g_s2[CNT_W-1];
        for (int i = CNT_W - 2; i >= 0; i--) begin
            b_now[i] = b_now[i+1] ^ g_s2[i];
        end
    end

    assign span = b_now - b_prev;

    // Window timer and verdict: fast when the edge span exceeds WIN_CYC.
    always_ff @(posedge rc_clk) begin
        if (!rst_n) begin
            wcnt     <= '0;
            b_prev   <= '0;
            primed   <= 1'b0;
            win_done <= 1'b0;
            win_fast <= 1'b0;
        end else begin
            win_done <= 1'b0;
            win_fast <= 1'b0;
            if (wcnt == WC_LAST) begin
                wcnt     <= '0;
                b_prev   <= b_now;
                primed   <= 1'b1;
                win_done <= 1'b1;
                win_fast <= primed && (span > WIN_REF);
            end else begin
                wcnt <= wcnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/osw_ctrl.sv
`timescale 1ns/1ps
// Module: supervisor state machine in the RC domain.
// Qualifies the external clock over GOOD_WIN good windows, then waits
// DELAY_CYC cycles, and decides the clock source and reset hold.
// Assumes: hwpd_s and run_s are already synchronized to rc_clk.
module osw_ctrl
    import osw_pkg::*;
#(
    parameter int GOOD_WIN  = 3,
    parameter int DELAY_CYC = 200
) (
    input  logic rc_clk,
    input  logic rst_n,
    input  logic win_done,
    input  logic win_fast,
    input  logic hwpd_s,
    input  logic run_s,
    output logic core_rst_n,
    output logic status,
    output logic want_rc,
    output logic want_ext
);
    localparam int STK_W = $clog2(GOOD_WIN + 1);
    localparam int DLY_W = $clog2(DELAY_CYC + 1);
    localparam logic [STK_W-1:0] STK_LAST = STK_W'(GOOD_WIN - 1);
    localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(DELAY_CYC - 1);

    osw_state_e       state;
    logic             cold;
    logic [STK_W-1:0] streak;
    logic [DLY_W-1:0] dly;
    logic             hold_phase;
    logic             bad_win;

    assign bad_win = win_done && !win_fast;

    // State transitions; power-down pin overrides every state.
    always_ff @(posedge rc_clk) begin
        if (!rst_n) begin
            state  <= ST_QUAL;
            cold   <= 1'b1;
            streak <= '0;
            dly    <= '0;
        end else if (!hwpd_s) begin
            state  <= ST_PD;
            streak <= '0;
        end else begin
            case (state)
                ST_PD: begin
                    state  <= ST_QUAL;
                    cold   <= 1'b1;
                    streak <= '0;
                end
                ST_QUAL: begin
                    if (win_done) begin
                        if (!win_fast) begin
                            streak <= '0;
                        end else if (streak == STK_LAST) begin
                            state  <= ST_DELAY;
                            dly    <= '0;
                            streak <= '0;
                        end else begin
                            streak <= streak + 1'b1;
                        end
                    end
                end
                ST_DELAY: begin
                    if (bad_win) begin
                        state  <= ST_QUAL;
                        streak <= '0;
                    end else if (dly == DLY_LAST) begin
                        state <= ST_RUN;
                    end else begin
                        dly <= dly + 1'b1;
                    end
                end
                ST_RUN: begin
                    if (bad_win) begin
                        state  <= ST_QUAL;
                        cold   <= 1'b1;
                        streak <= '0;
                    end else if (!run_s) begin
                        state <= ST_SLEEP;
                    end
                end
                ST_SLEEP: begin
                    if (run_s) begin
                        state  <= ST_QUAL;
                        cold   <= 1'b0;
                        streak <= '0;
                    end
                end
                default: state <= ST_QUAL;
            endcase
        end
    end

    // Output decode: cold qualification holds the core on RC.
    always_comb begin
        hold_phase = (state == ST_QUAL) || (state == ST_DELAY);
        status     = cold && hold_phase;
        core_rst_n = rst_n && !(status || (state == ST_PD));
        want_rc    = status;
        want_ext   = (state == ST_RUN);
    end
endmodule

// File: rtl/osw_clk_switch.sv
`timescale 1ns/1ps
// Module: glitch-free two-source clock switch.
// Each source has a two-flop enable chain that waits for the other source
// to be off; enables change only while their own clock is low.
// Assumes: a dead external clock cannot clear its own chain, so an RC-timed
// kill clears it after KILL_CYC cycles without acknowledgement.
module osw_clk_switch #(
    parameter int KILL_CYC = 16
) (
    input  logic rc_clk,
    input  logic rst_n,
    input  logic ext_clk,
    input  logic want_rc,
    input  logic want_ext,
    output logic rc_on,
    output logic ext_on,
    output logic core_clk
);
    localparam int KT_W = $clog2(KILL_CYC + 1);
    localparam logic [KT_W-1:0] KT_LAST = KT_W'(KILL_CYC - 1);

    logic            rc_s1, ex_s1;
    logic            eo_s1, eo_s2;
    logic            kill;
    logic [KT_W-1:0] ktmr;

    // RC chain first stage: request gated by the external enable.
    always_ff @(posedge rc_clk) begin
        if (!rst_n) rc_s1 <= 1'b0;
        else        rc_s1 <= want_rc && !ext_on;
    end

    // RC chain second stage: enable changes while rc_clk is low.
    always_ff @(negedge rc_clk) begin
        if (!rst_n) rc_on <= 1'b0;
        else        rc_on <= rc_s1;
    end

    // Bring the external enable back into the RC domain.
    always_ff @(posedge rc_clk) begin
        if (!rst_n) begin
            eo_s1 <= 1'b0;
            eo_s2 <= 1'b0;
        end else begin
            eo_s1 <= ext_on;
            eo_s2 <= eo_s1;
        end
    end

    // Kill timer: clears a stuck external enable when its clock is dead.
    always_ff @(posedge rc_clk) begin
        if (!rst_n) begin
            ktmr <= '0;
            kill <= 1'b1;
        end else if (want_ext) begin
            ktmr <= '0;
            kill <= 1'b0;
        end else if (eo_s2 && !kill) begin
            if (ktmr == KT_LAST) kill <= 1'b1;
            else                 ktmr <= ktmr + 1'b1;
        end else begin
            ktmr <= '0;
        end
    end

    // External chain first stage: request gated by the RC enable.
    always_ff @(posedge ext_clk or posedge kill) begin
        if (kill) ex_s1 <= 1'b0;
        else      ex_s1 <= want_ext && !rc_on;
    end

    // External chain second stage: enable changes while ext_clk is low.
    always_ff @(negedge ext_clk or posedge kill) begin
        if (kill) ext_on <= 1'b0;
        else      ext_on <= ex_s1;
    end

    assign core_clk = (rc_clk && rc_on) || (ext_clk && ext_on);
endmodule

// File: rtl/osw_supervisor.sv
`timescale 1ns/1ps
// Module: oscillator watchdog clock supervisor (top).
// Measures the external clock against the RC clock, holds the core in
// reset on RC while the oscillator is bad, and switches clean clocks.
// Assumes: rc_clk always runs; hwpd_n and run_req are asynchronous.
module osw_supervisor #(
    parameter int WIN_CYC   = 16,
    parameter int CNT_W     = 8,
    parameter int GOOD_WIN  = 3,
    parameter int DELAY_CYC = 200,
    parameter int KILL_CYC  = 16
) (
    input  logic rc_clk,
    input  logic rst_n,
    input  logic ext_clk,
    input  logic hwpd_n,
    input  logic run_req,
    output logic core_clk,
    output logic core_rst_n,
    output logic osc_fail_sts
);
    logic hwpd_s, run_s;
    logic win_done, win_fast;
    logic want_rc, want_ext;
    logic rc_on, ext_on;

    osw_sync #(.RST_VAL(1'b1)) u_hwpd_sync (
        .clk(rc_clk), .rst_n(rst_n), .d_async(hwpd_n), .q_sync(hwpd_s)
    );

    osw_sync #(.RST_VAL(1'b1)) u_run_sync (
        .clk(rc_clk), .rst_n(rst_n), .d_async(run_req), .q_sync(run_s)
    );

    osw_edge_meter #(.WIN_CYC(WIN_CYC), .CNT_W(CNT_W)) u_meter (
        .rc_clk(rc_clk), .rst_n(rst_n), .ext_clk(ext_clk),
        .win_done(win_done), .win_fast(win_fast)
    );

    osw_ctrl #(.GOOD_WIN(GOOD_WIN), .DELAY_CYC(DELAY_CYC)) u_ctrl (
        .rc_clk(rc_clk), .rst_n(rst_n),
        .win_done(win_done), .win_fast(win_fast),
        .hwpd_s(hwpd_s), .run_s(run_s),
        .core_rst_n(core_rst_n), .status(osc_fail_sts),
        .want_rc(want_rc), .want_ext(want_ext)
    );

    osw_clk_switch #(.KILL_CYC(KILL_CYC)) u_switch (
        .rc_clk(rc_clk), .rst_n(rst_n), .ext_clk(ext_clk),
        .want_rc(want_rc), .want_ext(want_ext),
        .rc_on(rc_on), .ext_on(ext_on), .core_clk(core_clk)
    );
endmodule

// File: rtl/osw_supervisor_chk.sv
`timescale 1ns/1ps
// Module: assertion checker bound to osw_supervisor.
// Assumes: sampled on rc_clk; the source enables come from the two
// independent chains inside the clock switch.
module osw_supervisor_chk #(
    parameter int DELAY_CYC = 200
) (
    input logic rc_clk,
    input logic rst_n,
    input logic hwpd_n,
    input logic core_rst_n,
    input logic osc_fail_sts,
    input logic rc_on,
    input logic ext_on
);
    localparam int LC_W = $clog2(DELAY_CYC + 1) + 1;
    localparam logic [LC_W-1:0] LC_MAX = '1;
    localparam logic [LC_W-1:0] LC_REQ = LC_W'(DELAY_CYC);

    logic [LC_W-1:0] low_cnt;

    // Saturating count of consecutive cycles with the core held.
    always_ff @(posedge rc_clk) begin
        if (!rst_n)              low_cnt <= '0;
        else if (core_rst_n)     low_cnt <= '0;
        else if (low_cnt != LC_MAX) low_cnt <= low_cnt + 1'b1;
    end

    // R9
    no_dual_src_chk: assert property (@(posedge rc_clk) disable iff (!rst_n)
        !(rc_on && ext_on));

    // R10
    stat_implies_hold_chk: assert property (@(posedge rc_clk) disable iff (!rst_n)
        osc_fail_sts |-> !core_rst_n);

    // R7
    pd_forces_hold_chk: assert property (@(posedge rc_clk) disable iff (!rst_n)
        $past(!hwpd_n, 3) |-> !core_rst_n);

    // R3
    release_after_delay_chk: assert property (@(posedge rc_clk) disable iff (!rst_n)
        $rose(core_rst_n) |-> (low_cnt >= LC_REQ));
endmodule

bind osw_supervisor osw_supervisor_chk #(.DELAY_CYC(DELAY_CYC)) u_chk (
    .rc_clk(rc_clk), .rst_n(rst_n), .hwpd_n(hwpd_n),
    .core_rst_n(core_rst_n), .osc_fail_sts(osc_fail_sts),
    .rc_on(rc_on), .ext_on(ext_on)
);

// File: tb/osw_supervisor_tb_top.sv
`timescale 1ns/1ps
// Bench: scoreboard driven. The driver pushes expected port states with
// their cycle; the monitor pops and compares them at the falling RC edge.
module osw_supervisor_tb_top;
    localparam int B = 10;          // reset release cycle
    localparam int SRC_X   = -1;    // source not checked
    localparam int SRC_OFF = 0;
    localparam int SRC_RC  = 1;
    localparam int SRC_EXT = 2;
    localparam int SRC_MIX = 3;

    logic rc_clk = 1'b0;
    logic ext_clk = 1'b0;
    logic rst_n = 1'b0;
    logic hwpd_n = 1'b1;
    logic run_req = 1'b1;
    logic core_clk, core_rst_n, osc_fail_sts;

    real ext_half = 2.0;
    bit  ext_run = 1'b1;

    int cyc = 0;
    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    int q_cyc[$];
    bit q_rst[$];
    bit q_st[$];
    int q_src[$];
    string q_tag[$];

    int cc = 0;
    int hist[32];
    real last_t = -1.0;
    real min_w = 1000.0;

    osw_supervisor dut_i (
        .rc_clk(rc_clk), .rst_n(rst_n), .ext_clk(ext_clk),
        .hwpd_n(hwpd_n), .run_req(run_req),
        .core_clk(core_clk), .core_rst_n(core_rst_n),
        .osc_fail_sts(osc_fail_sts)
    );

    // 100 MHz RC reference
    always #5 rc_clk = ~rc_clk;

    // External oscillator: adjustable half period, phase kept off RC edges
    initial begin
        #0.3;
        forever begin
            #(ext_half);
            if (ext_run) ext_clk = ~ext_clk;
        end
    end

    always @(posedge rc_clk) cyc <= cyc + 1;
    always @(posedge core_clk) cc <= cc + 1;

    // Narrowest core clock phase
    always @(core_clk) begin
        if (last_t >= 0.0 && ($realtime - last_t) < min_w) min_w = $realtime - last_t;
        last_t = $realtime;
    end

    function automatic int classify(int n);
        if (n <= 2) return SRC_OFF;
        if (n >= 15 && n <= 25) return SRC_RC;
        if (n >= 40) return SRC_EXT;
        return SRC_MIX;
    endfunction

    task automatic expect_at(int at, bit r, bit s, int src, string tag);
        q_cyc.push_back(at);
        q_rst.push_back(r);
        q_st.push_back(s);
        q_src.push_back(src);
        q_tag.push_back(tag);
    endtask

    task automatic wait_until(int c);
        while (cyc < c) @(negedge rc_clk);
    endtask

    // Monitor: edge history and scoreboard compare away from posedge
    always @(negedge rc_clk) begin
        int got_src;
        got_src = classify(cc - hist[(cyc + 12) % 32]);
        hist[cyc % 32] = cc;
        while (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
            vectors++;
            if (core_rst_n !== q_rst[0] || osc_fail_sts !== q_st[0] ||
                (q_src[0] != SRC_X && got_src != q_src[0])) begin
                miscompares++;
                $display("FAIL %s @%0d: rst=%0b st=%0b src=%0d, expected rst=%0b st=%0b src=%0d",
                         q_tag[0], cyc, core_rst_n, osc_fail_sts, got_src,
                         q_rst[0], q_st[0], q_src[0]);
            end
            void'(q_cyc.pop_front());
            void'(q_rst.pop_front());
            void'(q_st.pop_front());
            void'(q_src.pop_front());
            q_tag.pop_front();
        end
    end

    // Driver: expected items in cycle order
    initial begin
        expect_at(6,        0, 1, SRC_X,   "R1 reset state");
        expect_at(B+240,    0, 1, SRC_RC,  "R1/R3/R4 before earliest release");
        expect_at(B+300,    1, 0, SRC_EXT, "R3 released on external");
        expect_at(B+358,    0, 1, SRC_X,   "R5 slow clock detected");
        expect_at(B+380,    0, 1, SRC_RC,  "R5/R4 fallback to RC");
        expect_at(B+700,    0, 1, SRC_RC,  "R2 equal frequency not good");
        expect_at(B+760,    0, 1, SRC_RC,  "R2 stopped clock not good");
        expect_at(B+1000,   0, 1, SRC_RC,  "R3 lower bound after recovery");
        expect_at(B+1060,   1, 0, SRC_EXT, "R3 upper bound after recovery");
        expect_at(B+1140,   0, 0, SRC_OFF, "R7 power-down hold");
        expect_at(B+1240,   0, 1, SRC_RC,  "R7/R10 slow start after power-down");
        expect_at(B+1490,   0, 1, SRC_RC,  "R7 lower bound");
        expect_at(B+1550,   1, 0, SRC_EXT, "R7 upper bound");
        expect_at(B+1630,   1, 0, SRC_OFF, "R8 sleep gates clock");
        expect_at(B+1690,   1, 0, SRC_OFF, "R8 wake with dead oscillator");
        expect_at(B+1940,   1, 0, SRC_OFF, "R8 lower bound");
        expect_at(B+2020,   1, 0, SRC_EXT, "R8 clock after qualification");
        expect_at(B+2145,   0, 1, SRC_X,   "R5 second failure");
        expect_at(B+2500,   0, 1, SRC_RC,  "R6 delay abandoned");
        expect_at(B+2620,   1, 0, SRC_EXT, "R6 release after requalify");
    end

    // Stimulus
    initial begin
        wait_until(B);
        rst_n = 1'b1;
        wait_until(B+320);  ext_half = 10.0;
        wait_until(B+400);  ext_half = 5.0;
        wait_until(B+700);  ext_run = 1'b0;
        wait_until(B+760);  ext_half = 2.0; ext_run = 1'b1;
        wait_until(B+1100); hwpd_n = 1'b0;
        wait_until(B+1150); hwpd_n = 1'b1; ext_half = 10.0;
        wait_until(B+1250); ext_half = 2.0;
        wait_until(B+1600); run_req = 1'b0; ext_run = 1'b0;
        wait_until(B+1650); run_req = 1'b1;
        wait_until(B+1700); ext_run = 1'b1;
        wait_until(B+2100); ext_half = 10.0;
        wait_until(B+2150); ext_half = 2.0;
        wait_until(B+2260); ext_half = 10.0;
        wait_until(B+2310); ext_half = 2.0;
        wait_until(B+2700);
        // R9: no runt pulse on the core clock
        vectors++;
        if (min_w < 1.9) begin
            miscompares++;
            $display("FAIL R9 narrowest core_clk phase %0.2f ns, expected >= 1.90 ns", min_w);
        end
        if (q_cyc.size() != 0) begin
            miscompares++;
            $display("FAIL scoreboard: %0d items not compared, expected 0", q_cyc.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    // Watchdog
    initial begin
        #100us;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: run hung at cycle %0d, expected end by %0d", cyc, B+2700);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule